// File: doc/BRIEF.md
# Two-Wire Slave Front End with Target Routing

This block is the bus-facing half of a two-wire serial slave. It takes the raw clock and data lines, filters short pulses off them, recognises bus conditions, and runs the byte and acknowledge sequencing of a slave transaction. One address decoder picks one of three back ends by the upper nibble of the address byte: a bank of 16-bit sensor registers, a byte-wide memory, or a write-protect command unit. The three address-pin inputs must match the address bits that follow the nibble.

Received bytes reach the selected back end as single-cycle pulses: the first byte after a write address is the pointer, and the bytes after it are data. Sensor traffic is moved as 16-bit words (high byte first). Memory and protect traffic is moved one byte at a time. For a read, the block asks the back end for the next item with a request pulse and shifts it out on the data line. A clock line held low for too long during a transaction resets the interface and releases the data line.

Top module: `smb_slave_fe`

## Requirements
- R1: The block reacts to nothing until a START (data falls while clock is high). A STOP (data rises while clock is high) ends the transaction. `stop_o` pulses once on a STOP that closes a transaction whose address was accepted. After reset `sda_oe` is 0 and `tgt` is 0.
- R2: The address byte is accepted when its bits [3:1] equal `pin_addr` and its bits [7:4] are one of three preambles. The preamble 0011 selects sensor registers (`tgt`=1), 1010 selects memory (`tgt`=2), and 0110 selects protect commands (`tgt`=3). Bit 0 set means read. An accepted address is ACKed by driving `sda_oe` high across the 9th clock.
- R3: An address with any other preamble, or with pin bits that do not match, is NACKed. The block then ignores all traffic until the next START.
- R4: In a write, every received byte is ACKed. The first byte after the address pulses `ptr_valid` with the byte on `wr_data[7:0]`.
- R5: For the sensor target, the data bytes after the pointer are paired: the first byte is the high byte and the second is the low byte. `wr_valid` pulses once per pair with the 16-bit word. For memory and protect targets, `wr_valid` pulses per byte with the upper 8 bits zero.
- R6: In a read, `rd_req` pulses whenever a new item is loaded, and `rd_data` is sampled in that cycle. A sensor item is sent high byte then low byte. A memory or protect item is `rd_data[7:0]`. Bits go out MSB first and change only after SCL falls.
- R7: When the master NACKs a transmitted byte, the block stops driving and releases the line until the next START.
- R8: A repeated START in the middle of a transaction restarts the address phase, which gives a selective read after a data-less write.
- R9: If SCL stays low for `TIMEOUT_CYC` clocks between START and STOP, the block releases SDA, clears `tgt` and idles. The count restarts whenever SCL is high.
- R10: A level on SCL or SDA shorter than `FILT_CYC` clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired-AND bus level) |
| pin_addr | input | 3 | Address pin levels to match |
| sda_oe | output | 1 | 1 pulls the data line low |
| tgt | output | 2 | Selected back end (0 none, 1 sensor, 2 memory, 3 protect) |
| ptr_valid | output | 1 | Pointer byte pulse |
| wr_valid | output | 1 | Write data pulse |
| wr_data | output | 16 | Pointer byte or write word/byte |
| rd_req | output | 1 | Request for the next read item |
| rd_data | input | 16 | Read item from the back end |
| stop_o | output | 1 | End-of-transaction pulse for an accepted address |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that every intended level on either line lasts well beyond `FILT_CYC` clocks after synchronisation, so both filtered lines keep their relative order. The stimulus holds each quarter of a bit period for 20 clocks against a 5-clock filter. Its only short pulses are the deliberate 3-clock glitches. Every clock-low phase is shorter than the timeout, except in the one timeout case.

// File: rtl/smb_fe_pkg.sv
package smb_fe_pkg;
  localparam logic [1:0] TGT_NONE = 2'd0;
  localparam logic [1:0] TGT_SENS = 2'd1;
  localparam logic [1:0] TGT_MEM  = 2'd2;
  localparam logic [1:0] TGT_PROT = 2'd3;

  localparam logic [3:0] PRE_SENS = 4'b0011;
  localparam logic [3:0] PRE_MEM  = 4'b1010;
  localparam logic [3:0] PRE_PROT = 4'b0110;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_WAIT
  } fe_state_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          out_q, out_n;

  always_comb begin
    cnt_n = cnt_q;
    out_n = out_q;
    if (sync_q[1] == out_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cnt_n = '0;
      out_n = sync_q[1];
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      cnt_q  <= cnt_n;
      out_q  <= out_n;
    end
  end

  assign line_o = out_q;

  // R10
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_q[1]) == out_q));
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_f;
      sda_prev_q <= sda_f;
    end
  end

  assign start_p = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
  assign stop_p  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
  assign rise_p  = scl_f & ~scl_prev_q;
  assign fall_p  = ~scl_f & scl_prev_q;
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_fe_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_p,
  input  logic        stop_p,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        scl_lvl,
  input  logic        sda_lvl,
  input  logic [2:0]  pins,
  input  logic [15:0] rd_data,
  output logic        sda_oe,
  output logic [1:0]  tgt,
  output logic        ptr_valid,
  output logic        wr_valid,
  output logic [15:0] wr_data,
  output logic        rd_req,
  output logic        stop_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  fe_state_e     st_q, st_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [7:0]    sh_q, sh_n;
  logic [7:0]    msb_q, msb_n;
  logic [15:0]   word_q, word_n;
  logic [1:0]    tgt_q, tgt_n, dec_tgt;
  logic          rnw_q, rnw_n;
  logic          first_q, first_n;
  logic          half_q, half_n;
  logic          acked_q, acked_n;
  logic          oe_q, oe_n;
  logic          bus_q, bus_n;
  logic [TW-1:0] to_q, to_n;
  logic          to_hit, do_load;
  logic          ptr_q, ptr_n, wr_q, wr_n, rdr_q, rdr_n, stp_q, stp_n;
  logic [15:0]   wd_q, wd_n;

  always_comb begin
    dec_tgt = TGT_NONE;
    if (sh_q[3:1] == pins) begin
      case (sh_q[7:4])
        PRE_SENS: dec_tgt = TGT_SENS;
        PRE_MEM:  dec_tgt = TGT_MEM;
        PRE_PROT: dec_tgt = TGT_PROT;
        default:  dec_tgt = TGT_NONE;
      endcase
    end
  end

  assign to_hit = bus_q && !scl_lvl && (to_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  sh_n = sh_q;  msb_n = msb_q;
    word_n = word_q;  tgt_n = tgt_q;  rnw_n = rnw_q;  first_n = first_q;
    half_n = half_q;  acked_n = acked_q;  oe_n = oe_q;  bus_n = bus_q;
    ptr_n = 1'b0;  wr_n = 1'b0;  rdr_n = 1'b0;  stp_n = 1'b0;  wd_n = wd_q;
    do_load = 1'b0;
    to_n = (!bus_q || scl_lvl) ? '0 : to_q + TW'(1);

    if (start_p) begin
      st_n = S_ADDR;  cnt_n = '0;  oe_n = 1'b0;  bus_n = 1'b1;
      tgt_n = TGT_NONE;  to_n = '0;
    end else if (stop_p) begin
      stp_n = bus_q && (tgt_q != TGT_NONE);
      st_n = S_IDLE;  oe_n = 1'b0;  bus_n = 1'b0;
    end else if (to_hit) begin
      st_n = S_IDLE;  oe_n = 1'b0;  bus_n = 1'b0;  tgt_n = TGT_NONE;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (rise_p && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_lvl};
            cnt_n = cnt_q + 4'd1;
          end else if (fall_p && cnt_q == 4'd8) begin
            if (dec_tgt != TGT_NONE) begin
              tgt_n = dec_tgt;  rnw_n = sh_q[0];  oe_n = 1'b1;  st_n = S_AACK;
            end else begin
              st_n = S_WAIT;
            end
          end
        end
        S_AACK: begin
          if (fall_p) begin
            oe_n = 1'b0;  cnt_n = '0;
            if (rnw_q) begin
              do_load = 1'b1;
            end else begin
              st_n = S_WDATA;  first_n = 1'b1;  half_n = 1'b0;
            end
          end
        end
        S_WDATA: begin
          if (rise_p && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_lvl};
            cnt_n = cnt_q + 4'd1;
          end else if (fall_p && cnt_q == 4'd8) begin
            oe_n = 1'b1;  st_n = S_WACK;
            if (first_q) begin
              ptr_n = 1'b1;  wd_n = {8'h00, sh_q};  first_n = 1'b0;
            end else if (tgt_q == TGT_SENS) begin
              if (!half_q) begin
                msb_n = sh_q;  half_n = 1'b1;
              end else begin
                wr_n = 1'b1;  wd_n = {msb_q, sh_q};  half_n = 1'b0;
              end
            end else begin
              wr_n = 1'b1;  wd_n = {8'h00, sh_q};
            end
          end
        end
        S_WACK: begin
          if (fall_p) begin
            oe_n = 1'b0;  cnt_n = '0;  st_n = S_WDATA;
          end
        end
        S_RDATA: begin
          if (rise_p && cnt_q < 4'd8) begin
            cnt_n = cnt_q + 4'd1;
          end else if (fall_p) begin
            if (cnt_q == 4'd8) begin
              oe_n = 1'b0;  st_n = S_RACK;
            end else if (cnt_q != 4'd0) begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        S_RACK: begin
          if (rise_p) begin
            acked_n = ~sda_lvl;
          end else if (fall_p) begin
            if (!acked_q) begin
              st_n = S_WAIT;  oe_n = 1'b0;
            end else if (tgt_q == TGT_SENS && half_q) begin
              sh_n = word_q[7:0];  oe_n = ~word_q[7];  half_n = 1'b0;
              cnt_n = '0;  st_n = S_RDATA;
            end else begin
              do_load = 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (do_load) begin
        rdr_n = 1'b1;  cnt_n = '0;  st_n = S_RDATA;
        if (tgt_q == TGT_SENS) begin
          word_n = rd_data;  sh_n = rd_data[15:8];  oe_n = ~rd_data[15];
          half_n = 1'b1;
        end else begin
          sh_n = rd_data[7:0];  oe_n = ~rd_data[7];  half_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  cnt_q <= '0;  sh_q <= '0;  msb_q <= '0;  word_q <= '0;
      tgt_q <= TGT_NONE;  rnw_q <= 1'b0;  first_q <= 1'b0;  half_q <= 1'b0;
      acked_q <= 1'b0;  oe_q <= 1'b0;  bus_q <= 1'b0;  to_q <= '0;
      ptr_q <= 1'b0;  wr_q <= 1'b0;  rdr_q <= 1'b0;  stp_q <= 1'b0;  wd_q <= '0;
    end else begin
      st_q <= st_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  msb_q <= msb_n;
      word_q <= word_n;  tgt_q <= tgt_n;  rnw_q <= rnw_n;  first_q <= first_n;
      half_q <= half_n;  acked_q <= acked_n;  oe_q <= oe_n;  bus_q <= bus_n;
      to_q <= to_n;  ptr_q <= ptr_n;  wr_q <= wr_n;  rdr_q <= rdr_n;
      stp_q <= stp_n;  wd_q <= wd_n;
    end
  end

  assign sda_oe    = oe_q;
  assign tgt       = tgt_q;
  assign ptr_valid = ptr_q;
  assign wr_valid  = wr_q;
  assign wr_data   = wd_q;
  assign rd_req    = rdr_q;
  assign stop_o    = stp_q;

  // R2
  drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q == S_AACK || st_q == S_WACK || st_q == S_RDATA));
  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (!oe_q && st_q == S_IDLE && tgt_q == TGT_NONE));
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_q |-> (st_q == S_RDATA && cnt_q == 4'd0));
  // R4
  ptr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q |-> (st_q == S_WACK && oe_q && !rnw_q));
endmodule

// File: rtl/smb_slave_fe.sv
module smb_slave_fe #(
  parameter int FILT_CYC    = 5,
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  pin_addr,
  output logic        sda_oe,
  output logic [1:0]  tgt,
  output logic        ptr_valid,
  output logic        wr_valid,
  output logic [15:0] wr_data,
  output logic        rd_req,
  input  logic [15:0] rd_data,
  output logic        stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic start_p, stop_p, rise_p, fall_p;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    smb_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  smb_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  smb_xfer_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .scl_lvl   (filt_lines[0]),
    .sda_lvl   (filt_lines[1]),
    .pins      (pin_addr),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .tgt       (tgt),
    .ptr_valid (ptr_valid),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .stop_o    (stop_o)
  );
endmodule

// File: tb/test_smb_slave_fe.sv
module test_smb_slave_fe;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 20;
  localparam int TO  = 300;
  localparam logic [2:0] PINS = 3'b101;

  logic clk, rst_n, m_scl, m_sda, bus_sda;
  logic sda_oe, ptr_valid, wr_valid, rd_req, stop_o;
  logic [1:0] tgt;
  logic [15:0] wr_data, rd_data;
  int checks, fails, rd_idx;
  bit done;
  logic [21:0] expq[$];

  assign bus_sda = m_sda & ~sda_oe;

  smb_slave_fe #(.FILT_CYC(5), .TIMEOUT_CYC(TO)) i_smb_slave_fe (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .pin_addr(PINS),
    .sda_oe(sda_oe), .tgt(tgt), .ptr_valid(ptr_valid), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .stop_o(stop_o));

  function automatic logic [15:0] word_f(int i);
    return 16'h9C3A + 16'(i) * 16'h1B07;
  endfunction

  assign rd_data = word_f(rd_idx);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ptr_valid || wr_valid || rd_req || stop_o)) begin
      logic [21:0] got, exp;
      if (ptr_valid)     got = {4'd1, tgt, wr_data};
      else if (wr_valid) got = {4'd2, tgt, wr_data};
      else if (rd_req)   got = {4'd3, tgt, 16'h0};
      else               got = {4'd4, tgt, 16'h0};
      if (rd_req) rd_idx++;
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R5/R6/R1 unexpected event", 32'(got), 32'h0);
      end else begin
        exp = expq.pop_front();
        chk(got == exp, "R4/R5/R6/R1 event", 32'(got), 32'(exp));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = bus_sda; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(~mack);
  endtask

  task automatic start_c;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  function automatic logic [21:0] ev(input int k, input logic [1:0] t,
                                     input logic [15:0] d);
    return {4'(k), t, d};
  endfunction

  initial begin
    logic ack;
    logic [7:0] b;
    int ei;
    checks = 0; fails = 0; rd_idx = 0; done = 0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 reset sda_oe", 32'(sda_oe), 0);
    chk(tgt == 2'd0, "R1 reset tgt", 32'(tgt), 0);

    // R1 traffic without START is ignored
    m_scl = 1'b0; tick(Q);
    send_byte({4'b1010, PINS, 1'b0}, ack);
    chk(!ack, "R1 no ack without START", 32'(ack), 0);
    send_byte(8'h10, ack);
    chk(!ack, "R1 no ack data without START", 32'(ack), 0);

    // R2 R4 R5 sensor write
    start_c;
    send_byte({4'b0011, PINS, 1'b0}, ack);
    chk(ack, "R2 sensor address ack", 32'(ack), 1);
    chk(tgt == 2'd1, "R2 sensor tgt", 32'(tgt), 1);
    expq.push_back(ev(1, 2'd1, 16'h0003));
    send_byte(8'h03, ack);
    chk(ack, "R4 pointer ack", 32'(ack), 1);
    send_byte(8'h12, ack);
    chk(ack, "R4 msb ack", 32'(ack), 1);
    expq.push_back(ev(2, 2'd1, 16'h1234));
    send_byte(8'h34, ack);
    chk(ack, "R4 lsb ack", 32'(ack), 1);
    expq.push_back(ev(4, 2'd1, 16'h0));
    stop_c;

    // R5 memory write, bytes individually
    start_c;
    send_byte({4'b1010, PINS, 1'b0}, ack);
    chk(ack && tgt == 2'd2, "R2 memory address ack", 32'({ack, tgt}), 32'h6);
    expq.push_back(ev(1, 2'd2, 16'h0040));
    send_byte(8'h40, ack);
    expq.push_back(ev(2, 2'd2, 16'h0055));
    send_byte(8'h55, ack);
    expq.push_back(ev(2, 2'd2, 16'h00AA));
    send_byte(8'hAA, ack);
    chk(ack, "R4 memory data ack", 32'(ack), 1);
    expq.push_back(ev(4, 2'd2, 16'h0));
    stop_c;

    // R2 protect target
    start_c;
    send_byte({4'b0110, PINS, 1'b0}, ack);
    chk(ack && tgt == 2'd3, "R2 protect address ack", 32'({ack, tgt}), 32'h7);
    expq.push_back(ev(1, 2'd3, 16'h0000));
    send_byte(8'h00, ack);
    expq.push_back(ev(2, 2'd3, 16'h00C3));
    send_byte(8'hC3, ack);
    expq.push_back(ev(4, 2'd3, 16'h0));
    stop_c;

    // R8 R6 sensor selective read, two words
    start_c;
    send_byte({4'b0011, PINS, 1'b0}, ack);
    expq.push_back(ev(1, 2'd1, 16'h0005));
    send_byte(8'h05, ack);
    start_c;
    ei = rd_idx;
    expq.push_back(ev(3, 2'd1, 16'h0));
    send_byte({4'b0011, PINS, 1'b1}, ack);
    chk(ack, "R8 read address ack after repeated START", 32'(ack), 1);
    recv_byte(b, 1'b1);
    chk(b == word_f(ei)[15:8], "R6 sensor msb", 32'(b), 32'(word_f(ei)[15:8]));
    expq.push_back(ev(3, 2'd1, 16'h0));
    recv_byte(b, 1'b1);
    chk(b == word_f(ei)[7:0], "R6 sensor lsb", 32'(b), 32'(word_f(ei)[7:0]));
    recv_byte(b, 1'b1);
    chk(b == word_f(ei + 1)[15:8], "R6 sensor msb 2", 32'(b),
        32'(word_f(ei + 1)[15:8]));
    recv_byte(b, 1'b0);
    chk(b == word_f(ei + 1)[7:0], "R6 sensor lsb 2", 32'(b),
        32'(word_f(ei + 1)[7:0]));
    expq.push_back(ev(4, 2'd1, 16'h0));
    stop_c;

    // R6 R7 memory read, master NACK ends transmission
    start_c;
    ei = rd_idx;
    expq.push_back(ev(3, 2'd2, 16'h0));
    send_byte({4'b1010, PINS, 1'b1}, ack);
    for (int k = 0; k < 3; k++) begin
      if (k < 2) expq.push_back(ev(3, 2'd2, 16'h0));
      recv_byte(b, k < 2);
      chk(b == word_f(ei + k)[7:0], "R6 memory byte", 32'(b),
          32'(word_f(ei + k)[7:0]));
    end
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R7 released after master NACK", 32'(b), 32'hFF);
    expq.push_back(ev(4, 2'd2, 16'h0));
    stop_c;

    // R3 pin mismatch and bad preamble
    start_c;
    send_byte({4'b1010, ~PINS, 1'b0}, ack);
    chk(!ack, "R3 pin mismatch nack", 32'(ack), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 idle after mismatch", 32'(ack), 0);
    stop_c;
    start_c;
    send_byte({4'b1111, PINS, 1'b1}, ack);
    chk(!ack, "R3 preamble mismatch nack", 32'(ack), 0);
    stop_c;

    // R9 clock-low timeout during ACK
    start_c;
    for (int i = 7; i >= 0; i--) bit_out(((8'hA0 | {4'h0, PINS, 1'b0}) >> i) & 8'h01);
    tick(Q);
    chk(sda_oe == 1'b1, "R2 ack driven before timeout", 32'(sda_oe), 1);
    tick(TO + 100);
    chk(sda_oe == 1'b0, "R9 released after timeout", 32'(sda_oe), 0);
    chk(tgt == 2'd0, "R9 tgt cleared after timeout", 32'(tgt), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R9 idle after timeout", 32'(ack), 0);
    stop_c;

    // R10 short SDA dip while SCL high is not a START
    m_sda = 1'b0; tick(3); m_sda = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    send_byte({4'b1010, PINS, 1'b0}, ack);
    chk(!ack, "R10 glitch START ignored", 32'(ack), 0);

    // R10 short SCL spike inside an address byte
    start_c;
    for (int i = 7; i >= 0; i--) begin
      bit_out((({4'b1010, PINS, 1'b0}) >> i) & 8'h01);
      if (i == 4) begin m_scl = 1'b1; tick(3); m_scl = 1'b0; tick(Q); end
    end
    bit_in(b[0]);
    chk(b[0] == 1'b0, "R10 spike ignored, address acked", 32'(b[0]), 0);
    expq.push_back(ev(4, 2'd2, 16'h0));
    stop_c;
    tick(50);

    chk(expq.size() == 0, "R1 all expected events seen", 32'(expq.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule